// File: doc/BRIEF.md
# Windowed Short-Circuit Event Detector

This block sits beside a pulse-width modulator and decides, cycle by cycle, whether the converter is working into a short circuit. A cycle is marked as an event when the current-limit strobe fires while the oscillator ramp is still at or below a threshold. The threshold is a share of the maximum ramp value, programmed through a set value. An early current limit therefore stands for a duty cycle that limiting has cut well short.

Isolated events are tolerated. The block keeps a record of the most recent completed cycles and raises a single-clock shutdown request once enough of them are events. After a request, detection stays quiet until soft-start has dropped and completed again. A zero set value, a low enable or an unfinished soft-start keep detection disarmed, and the record stays empty while disarmed.

Top module: `sc_event_window`

## Requirements
- R1: While reset is held and on the first clock after it, `sc_req` is low and the cycle history holds no events.
- R2: The threshold is floor(`ramp_max` * `sc_set` / 2^SET_W), so `sc_set` = 128 of 256 gives half of `ramp_max`. While armed, a current-limit strobe with `ramp` at or below the threshold (equality included) marks the current cycle as an event.
- R3: A current-limit strobe with `ramp` above the threshold marks no event.
- R4: With `sc_set` equal to zero, detection is disarmed and `sc_req` never rises.
- R5: On each `cyc_start` strobe the cycle just closed enters a history of the last WIN = 32 completed cycles. When the events in that history reach LIMIT = 8, `sc_req` is high on the clock after that strobe.
- R6: Events spaced five cycles apart (at most 7 in any 32 cycles) never raise `sc_req`. Events spaced four apart do raise it.
- R7: `sc_req` is high for exactly one clock per request.
- R8: After a request the history is emptied and no further request is made until `ss_done` has been seen low and then high again.
- R9: A cycle counts as at most one event, however many current-limit strobes it contains.
- R10: With `ss_done` low or `en` low, detection is disarmed, the history is emptied and `sc_req` stays low. A current-limit strobe in the same clock as `cyc_start` belongs to the cycle that strobe opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Detector enable |
| cyc_start | input | 1 | One-clock strobe at the start of each oscillator cycle |
| ramp | input | RAMP_W | Present ramp value |
| ramp_max | input | RAMP_W | Ramp value at maximum duty |
| sc_set | input | SET_W | Threshold share of maximum duty, full scale 2^SET_W |
| ilim | input | 1 | Current-limit strobe |
| ss_done | input | 1 | Soft-start complete flag |
| sc_req | output | 1 | One-clock shutdown request |

## Verification
The detector is driven with oscillator cycles of 20 clocks. The current limit is placed before the threshold, exactly at it, and after it, which checks the inclusive comparison. Event spacings of one, four and five cycles show whether the window length and the event limit are right, since only the four-spacing fits eight events into 32 cycles. Cycles with three current-limit strobes each show whether events are counted per cycle or per strobe. Runs with a zero set value, soft-start pending or the enable low, and runs after a request, check every disarming path. A behavioural queue model is compared with `sc_req` on every clock.

// File: rtl/sc_event_window.sv
module sc_event_window #(
  parameter int RAMP_W = 10,
  parameter int SET_W  = 8,
  parameter int WIN    = 32,
  parameter int LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cyc_start,
  input  logic [RAMP_W-1:0] ramp,
  input  logic [RAMP_W-1:0] ramp_max,
  input  logic [SET_W-1:0]  sc_set,
  input  logic              ilim,
  input  logic              ss_done,
  output logic              sc_req
);
  localparam int CNT_W  = $clog2(WIN + 1);
  localparam int PROD_W = RAMP_W + SET_W;

  logic [WIN-1:0]   hist;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             lockout;

  logic [PROD_W-1:0] prod;
  logic [RAMP_W-1:0] thr;
  logic              armed, hit, fire;
  logic [CNT_W-1:0]  cnt_next;

  assign prod     = PROD_W'(ramp_max) * PROD_W'(sc_set);
  assign thr      = prod[PROD_W-1:SET_W];
  assign armed    = en & ss_done & ~lockout & (sc_set != '0);
  assign hit      = armed & ilim & (ramp <= thr);
  assign cnt_next = cnt + CNT_W'(pend) - CNT_W'(hist[WIN-1]);
  assign fire     = armed & cyc_start & (cnt_next >= CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      lockout <= 1'b0;
      sc_req  <= 1'b0;
    end else begin
      sc_req <= fire;
      if (fire)          lockout <= 1'b1;
      else if (!ss_done) lockout <= 1'b0;
      if (!armed || fire) begin
        hist <= '0;
        cnt  <= '0;
        pend <= 1'b0;
      end else if (cyc_start) begin
        hist <= {hist[WIN-2:0], pend};
        cnt  <= cnt_next;
        pend <= hit;
      end else begin
        pend <= pend | hit;
      end
    end
  end

  a_r7_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !sc_req);

  a_r5_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |-> $past(cyc_start));

  a_r5_tally: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'($countones(hist)));

  a_r4_zero_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sc_set == '0) |-> (hist == '0 && !sc_req));

  a_r10_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> (hist == '0 && !sc_req));

  a_r8_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |-> (hist == '0 && lockout));
endmodule

// File: tb/sc_event_window_tb_top.sv
module sc_event_window_tb_top;
  localparam int RAMP_W = 10;
  localparam int SET_W  = 8;
  localparam int PER    = 20;
  localparam int STEP   = 50;

  logic clk = 1'b0;
  logic rst_n, en, cyc_start, ilim, ss_done;
  logic [RAMP_W-1:0] ramp, ramp_max;
  logic [SET_W-1:0]  sc_set;
  logic sc_req;

  int checks = 0, errors = 0, pulses = 0, clocks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_event_window #(.RAMP_W(RAMP_W), .SET_W(SET_W), .WIN(32), .LIMIT(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start), .ramp(ramp),
    .ramp_max(ramp_max), .sc_set(sc_set), .ilim(ilim), .ss_done(ss_done),
    .sc_req(sc_req));

  bit m_q[$];
  bit m_pend, m_lock, m_req, prev_req;

  always @(posedge clk) begin
    bit armed, hit, f;
    int sum;
    f = 1'b0;
    if (!rst_n) begin
      m_q = {}; m_pend = 0; m_lock = 0;
    end else begin
      armed = en && ss_done && !m_lock && sc_set != 0;
      hit = armed && ilim && (int'(ramp) <= (int'(ramp_max) * int'(sc_set)) / 256);
      if (!armed) begin
        m_q = {}; m_pend = 0;
      end else if (cyc_start) begin
        m_q.push_front(m_pend);
        if (m_q.size() > 32) void'(m_q.pop_back());
        sum = 0;
        foreach (m_q[i]) sum += m_q[i];
        if (sum >= 8) begin
          f = 1'b1; m_lock = 1'b1; m_q = {}; m_pend = 0;
        end else m_pend = hit;
      end else m_pend = m_pend | hit;
      if (!f && !ss_done) m_lock = 1'b0;
    end
    m_req = f;
  end

  always @(negedge clk) begin
    clocks++;
    if (rst_n && !done) begin
      checks++;
      if (sc_req !== m_req) begin
        errors++;
        $display("FAIL R5 model compare: sc_req=%0b expected %0b at clock %0d", sc_req, m_req, clocks);
      end
      if (sc_req && !prev_req) pulses++;
      if (sc_req && prev_req) begin
        checks++; errors++;
        $display("FAIL R7 request wider than one clock: actual 2+ expected 1");
      end
      prev_req = sc_req;
    end
    if (clocks > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_cycles(int n, int every, int pos, int reps);
    for (int c = 0; c < n; c++) begin
      bit ev = (every > 0) && (c % every == 0);
      for (int k = 0; k < PER; k++) begin
        @(negedge clk);
        cyc_start = (k == 0);
        ramp = RAMP_W'(k * STEP);
        ilim = ev && k >= pos && k < pos + 2 * reps && ((k - pos) % 2 == 0);
      end
    end
    @(negedge clk);
    cyc_start = 1'b1; ilim = 1'b0; ramp = '0;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rearm();
    @(negedge clk); ss_done = 1'b0;
    repeat (3) @(negedge clk);
    ss_done = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_pulses(string tag, int exp);
    checks++;
    if (pulses != exp) begin
      errors++;
      $display("FAIL %s request count: actual %0d expected %0d", tag, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    rst_n = 0; en = 1; cyc_start = 0; ilim = 0; ss_done = 0;
    ramp = '0; ramp_max = 10'd1000; sc_set = 8'd128;
    repeat (4) @(negedge clk);
    checks++;
    if (sc_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: sc_req=%0b expected 0", sc_req);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (sc_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: sc_req=%0b expected 0", sc_req);
    end
    pulses = 0;
    run_cycles(12, 1, 4, 1);  expect_pulses("R10 soft-start pending", 0);
    ss_done = 1;
    run_cycles(10, 1, 8, 1);  expect_pulses("R2 early limit", 1);
    run_cycles(12, 1, 8, 1);  expect_pulses("R8 held off", 0);
    rearm();
    run_cycles(12, 1, 11, 1); expect_pulses("R3 late limit", 0);
    rearm();
    run_cycles(9, 1, 10, 1);  expect_pulses("R2 equal threshold", 1);
    rearm();
    sc_set = 8'd0;
    run_cycles(12, 1, 0, 1);  expect_pulses("R4 zero set", 0);
    sc_set = 8'd128;
    rearm();
    run_cycles(45, 5, 4, 1);  expect_pulses("R6 spacing five", 0);
    rearm();
    run_cycles(33, 4, 4, 1);  expect_pulses("R6 spacing four", 1);
    rearm();
    run_cycles(7, 1, 2, 3);   expect_pulses("R9 repeated strobes", 0);
    run_cycles(1, 1, 2, 1);   expect_pulses("R9 eighth cycle", 1);
    rearm();
    en = 0;
    run_cycles(12, 1, 4, 1);  expect_pulses("R10 enable low", 0);
    en = 1;
    rearm();
    run_cycles(3, 1, 0, 1);   expect_pulses("R10 strobe-aligned limit", 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule